// File: doc/BRIEF.md
# Transfer-Mode Timing Register Programmer

This block loads the per-drive timing registers of one drive channel whenever software selects a new transfer mode. It is started with a one-cycle strobe that carries an ATA transfer-mode code, a drive-select bit and a flag that says whether the channel runs from the high-speed clock. It then reaches the channel's registers through an indexed port. Each access puts an index byte on a shared bus with an index strobe, then writes or reads the data byte with a data strobe. The timing bytes for every supported mode are held in a small internal ROM.

With the high-speed clock in use, the mode class picks the group of indexes to load: three for UDMA, two for multiword DMA, three for PIO. The low three bits of the code pick the ROM row. The second drive of the pair adds 0x08 to every index. Without the high-speed clock, the hardware loads its own timings, so the block only clears bit 7 of the first UDMA register by read-modify-write when UDMA mode 2 is selected. It touches nothing for any other supported mode. A code outside the supported set writes nothing and raises an error flag together with done.

The sequencer has these states: IDLE (waits for start), WIDX (index strobe before a write), WDAT (data write strobe), RIDX (index strobe before a read), RDAT (data read strobe and capture), DONE (one-cycle done pulse). Its transitions:
- IDLE→WIDX starts a fast-clock load.
- IDLE→RIDX starts the slow-clock UDMA 2 fix.
- IDLE→DONE covers an unsupported code or a slow-clock mode that needs no access.
- WIDX→WDAT always follows.
- WDAT→WIDX loads the next byte.
- WDAT→DONE follows the last byte.
- RIDX→RDAT, then RDAT→WIDX, finish the read-modify-write.
- DONE→IDLE always follows.

Top module: `xfer_timing_prog`

## Requirements
- R1: Every data strobe, whether write (`dat_wr`) or read (`dat_rd`), comes in the cycle right after an index strobe (`idx_wr`). While `idx_wr` is high, `port_data` carries the index. While `dat_wr` is high, it carries the data byte.
- R2: When `drive_sel`=1, 0x08 is added to every index. When `drive_sel`=0, no offset is added.
- R3: With `fast_clk`=1 and a UDMA code 0x40+m (m=0..6), the block writes three bytes, in this order, to indexes 0x10, 0x11 and 0x12:
  - m0: 4A 0F D5
  - m1: 3A 0A D0
  - m2: 2A 07 CD
  - m3: 1A 05 CD
  - m4: 1A 03 CD
  - m5: 1A 02 CB
  - m6: 1A 01 CB
- R4: With `fast_clk`=1 and a multiword DMA code 0x20+m (m=0..2), the block writes two bytes, in this order, to indexes 0x0E and 0x0F:
  - m0: DF 5F
  - m1: 6B 27
  - m2: 69 25
- R5: With `fast_clk`=1 and a PIO code 0x08+m (m=0..4), the block writes three bytes, in this order, to indexes 0x0C, 0x0D and 0x13:
  - m0: FB 2B AC
  - m1: 46 29 A4
  - m2: 23 26 64
  - m3: 27 0D 35
  - m4: 23 09 25
- R6: The ROM row is picked by bits [2:0] of the mode code. Each supported mode number therefore writes its own row.
- R7: With `fast_clk`=0 and code 0x42, the block reads index 0x10 (plus the offset), clears bit 7 of the value it read, and writes the result back to the same index. There is exactly one read and one write.
- R8: With `fast_clk`=0 and any supported code other than 0x42, the block makes no register access, asserts done and leaves `err` low.
- R9: An unsupported code causes no register access and asserts `err` in the same cycle as done. Every code outside 0x08–0x0C, 0x20–0x22 and 0x40–0x46 is unsupported.
- R10: `done` is high for exactly one cycle. When the run ends in a write, that cycle comes right after the cycle of the last data write.
- R11: `busy` is high from the cycle after an accepted start through the done cycle. A start that arrives while `busy` is high is ignored.
- R12: After reset, all strobes, `done`, `err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to program a mode |
| mode_code | input | 8 | ATA transfer-mode code |
| drive_sel | input | 1 | 0 = first drive, 1 = second drive (index +0x08) |
| fast_clk | input | 1 | High-speed channel clock in use |
| rd_data | input | 8 | Data byte read from the indexed port, sampled while dat_rd is high |
| port_data | output | 8 | Index or data byte for the indexed port |
| idx_wr | output | 1 | Index write strobe |
| dat_wr | output | 1 | Data write strobe |
| dat_rd | output | 1 | Data read strobe |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported mode, valid with done |
| busy | output | 1 | Sequence in progress |

## Verification
The hardest case to reach from the ports is a start that arrives while a load is in flight. It is easy to drop by accident, and hard to tell apart from a second, correct run. The bench starts a PIO load on the first drive and, two cycles later, pulses start with a UDMA code for the second drive. It then checks that the register model saw only the PIO bytes at the unshifted indexes, and that exactly one done pulse appeared. The slow-clock fix is reached by preloading the bench's register model with bit 7 set, then with bit 7 clear. This shows that the written-back byte comes from the value read and is not a constant.

// File: rtl/xtp_pkg.sv
package xtp_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_PIO   = 2'd1,
        CLS_MWDMA = 2'd2,
        CLS_UDMA  = 2'd3
    } xtp_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WIDX = 3'd1,
        ST_WDAT = 3'd2,
        ST_RIDX = 3'd3,
        ST_RDAT = 3'd4,
        ST_DONE = 3'd5
    } xtp_state_e;

endpackage

// File: rtl/xtp_mode_decode.sv
module xtp_mode_decode
    import xtp_pkg::*;
#(
    parameter logic [7:0] PIO_BASE  = 8'h08,
    parameter logic [7:0] MW_BASE   = 8'h20,
    parameter logic [7:0] UDMA_BASE = 8'h40,
    parameter logic [2:0] PIO_TOP   = 3'd4,
    parameter logic [2:0] MW_TOP    = 3'd2,
    parameter logic [2:0] UDMA_TOP  = 3'd6,
    parameter logic [2:0] FIX_MODE  = 3'd2
) (
    input  logic [7:0] mode_code,
    output xtp_cls_e   cls,
    output logic [2:0] row,
    output logic [1:0] nbytes,
    output logic       is_fix
);
    localparam logic [4:0] PIO_GRP  = PIO_BASE[7:3];
    localparam logic [4:0] MW_GRP   = MW_BASE[7:3];
    localparam logic [4:0] UDMA_GRP = UDMA_BASE[7:3];

    logic [4:0] grp;
    assign grp = mode_code[7:3];
    assign row = mode_code[2:0];

    always_comb begin
        cls    = CLS_NONE;
        nbytes = 2'd0;
        if (grp == UDMA_GRP && row <= UDMA_TOP) begin
            cls    = CLS_UDMA;
            nbytes = 2'd3;
        end else if (grp == MW_GRP && row <= MW_TOP) begin
            cls    = CLS_MWDMA;
            nbytes = 2'd2;
        end else if (grp == PIO_GRP && row <= PIO_TOP) begin
            cls    = CLS_PIO;
            nbytes = 2'd3;
        end
    end

    assign is_fix = (cls == CLS_UDMA) && (row == FIX_MODE);

endmodule

// File: rtl/xtp_timing_rom.sv
module xtp_timing_rom
    import xtp_pkg::*;
(
    input  xtp_cls_e   cls,
    input  logic [2:0] row,
    input  logic [1:0] step,
    output logic [7:0] idx_base,
    output logic [7:0] value
);
    logic [23:0] line;

    always_comb begin
        idx_base = 8'h00;
        unique case (cls)
            CLS_UDMA:  idx_base = 8'h10 + {6'd0, step};
            CLS_MWDMA: idx_base = 8'h0E + {6'd0, step};
            CLS_PIO:   idx_base = (step == 2'd2) ? 8'h13 : (8'h0C + {6'd0, step});
            default:   idx_base = 8'h00;
        endcase
    end

    always_comb begin
        line = 24'h000000;
        unique case (cls)
            CLS_UDMA: begin
                unique case (row)
                    3'd0:    line = 24'h4A0FD5;
                    3'd1:    line = 24'h3A0AD0;
                    3'd2:    line = 24'h2A07CD;
                    3'd3:    line = 24'h1A05CD;
                    3'd4:    line = 24'h1A03CD;
                    3'd5:    line = 24'h1A02CB;
                    default: line = 24'h1A01CB;
                endcase
            end
            CLS_MWDMA: begin
                unique case (row)
                    3'd0:    line = 24'hDF5F00;
                    3'd1:    line = 24'h6B2700;
                    default: line = 24'h692500;
                endcase
            end
            CLS_PIO: begin
                unique case (row)
                    3'd0:    line = 24'hFB2BAC;
                    3'd1:    line = 24'h4629A4;
                    3'd2:    line = 24'h232664;
                    3'd3:    line = 24'h270D35;
                    default: line = 24'h230925;
                endcase
            end
            default: line = 24'h000000;
        endcase
    end

    always_comb begin
        unique case (step)
            2'd0:    value = line[23:16];
            2'd1:    value = line[15:8];
            default: value = line[7:0];
        endcase
    end

endmodule

// File: rtl/xtp_sequencer.sv
module xtp_sequencer
    import xtp_pkg::*;
#(
    parameter logic [7:0] DRIVE_OFS = 8'h08,
    parameter int         FIX_BIT   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  xtp_cls_e   dec_cls,
    input  logic [2:0] dec_row,
    input  logic [1:0] dec_nbytes,
    input  logic       dec_fix,
    input  logic       drive_sel,
    input  logic       fast_clk,
    input  logic [7:0] rd_data,
    input  logic [7:0] rom_idx,
    input  logic [7:0] rom_val,
    output xtp_cls_e   rom_cls,
    output logic [2:0] rom_row,
    output logic [1:0] rom_step,
    output logic [7:0] port_data,
    output logic       idx_wr,
    output logic       dat_wr,
    output logic       dat_rd,
    output logic       done,
    output logic       err,
    output logic       busy
);
    localparam logic [7:0] FIX_MASK = ~(8'h01 << FIX_BIT);

    xtp_state_e st;
    xtp_cls_e   cls_q;
    logic [2:0] row_q;
    logic [1:0] nb_q;
    logic [1:0] step_q;
    logic       ofs_q;
    logic       rmw_q;
    logic       err_q;
    logic [7:0] hold_q;
    logic [7:0] index_now;

    assign rom_cls   = cls_q;
    assign rom_row   = row_q;
    assign rom_step  = step_q;
    assign index_now = rom_idx + (ofs_q ? DRIVE_OFS : 8'h00);

    // State register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cls_q  <= CLS_NONE;
            row_q  <= 3'd0;
            nb_q   <= 2'd0;
            step_q <= 2'd0;
            ofs_q  <= 1'b0;
            rmw_q  <= 1'b0;
            err_q  <= 1'b0;
            hold_q <= 8'h00;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        cls_q  <= dec_cls;
                        row_q  <= dec_row;
                        nb_q   <= dec_nbytes;
                        step_q <= 2'd0;
                        ofs_q  <= drive_sel;
                        rmw_q  <= !fast_clk;
                        err_q  <= (dec_cls == CLS_NONE);
                        if (dec_cls == CLS_NONE) begin
                            st <= ST_DONE;
                        end else if (fast_clk) begin
                            st <= ST_WIDX;
                        end else if (dec_fix) begin
                            st <= ST_RIDX;
                        end else begin
                            st <= ST_DONE;
                        end
                    end
                end
                ST_WIDX: st <= ST_WDAT;
                ST_WDAT: begin
                    if (rmw_q || step_q == nb_q - 2'd1) begin
                        st <= ST_DONE;
                    end else begin
                        step_q <= step_q + 2'd1;
                        st     <= ST_WIDX;
                    end
                end
                ST_RIDX: st <= ST_RDAT;
                ST_RDAT: begin
                    hold_q <= rd_data & FIX_MASK;
                    st     <= ST_WIDX;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        idx_wr    = 1'b0;
        dat_wr    = 1'b0;
        dat_rd    = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        busy      = (st != ST_IDLE);
        port_data = 8'h00;
        unique case (st)
            ST_WIDX, ST_RIDX: begin
                idx_wr    = 1'b1;
                port_data = index_now;
            end
            ST_WDAT: begin
                dat_wr    = 1'b1;
                port_data = rmw_q ? hold_q : rom_val;
            end
            ST_RDAT: dat_rd = 1'b1;
            ST_DONE: begin
                done = 1'b1;
                err  = err_q;
            end
            default: ;
        endcase
    end

    AST_DATA_AFTER_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr || dat_rd) |-> $past(idx_wr)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(dat_wr) && !$past(dat_rd)); // R9

    AST_FIX_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && rmw_q) |-> !port_data[FIX_BIT]); // R7

    AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(cls_q) && $stable(row_q) && $stable(ofs_q)); // R11

    AST_INDEX_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && ofs_q) |-> port_data >= 8'h14); // R2

endmodule

// File: rtl/xfer_timing_prog.sv
module xfer_timing_prog
    import xtp_pkg::*;
#(
    parameter logic [7:0] DRIVE_OFS = 8'h08,
    parameter logic [2:0] UDMA_TOP  = 3'd6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] mode_code,
    input  logic       drive_sel,
    input  logic       fast_clk,
    input  logic [7:0] rd_data,
    output logic [7:0] port_data,
    output logic       idx_wr,
    output logic       dat_wr,
    output logic       dat_rd,
    output logic       done,
    output logic       err,
    output logic       busy
);
    xtp_cls_e   dec_cls;
    logic [2:0] dec_row;
    logic [1:0] dec_nbytes;
    logic       dec_fix;
    xtp_cls_e   rom_cls;
    logic [2:0] rom_row;
    logic [1:0] rom_step;
    logic [7:0] rom_idx;
    logic [7:0] rom_val;

    xtp_mode_decode #(
        .UDMA_TOP (UDMA_TOP)
    ) u_dec (
        .mode_code (mode_code),
        .cls       (dec_cls),
        .row       (dec_row),
        .nbytes    (dec_nbytes),
        .is_fix    (dec_fix)
    );

    xtp_timing_rom u_rom (
        .cls      (rom_cls),
        .row      (rom_row),
        .step     (rom_step),
        .idx_base (rom_idx),
        .value    (rom_val)
    );

    xtp_sequencer #(
        .DRIVE_OFS (DRIVE_OFS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dec_cls    (dec_cls),
        .dec_row    (dec_row),
        .dec_nbytes (dec_nbytes),
        .dec_fix    (dec_fix),
        .drive_sel  (drive_sel),
        .fast_clk   (fast_clk),
        .rd_data    (rd_data),
        .rom_idx    (rom_idx),
        .rom_val    (rom_val),
        .rom_cls    (rom_cls),
        .rom_row    (rom_row),
        .rom_step   (rom_step),
        .port_data  (port_data),
        .idx_wr     (idx_wr),
        .dat_wr     (dat_wr),
        .dat_rd     (dat_rd),
        .done       (done),
        .err        (err),
        .busy       (busy)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> !idx_wr && !dat_wr && !dat_rd && !done && !busy); // R12

endmodule

// File: tb/sim_xfer_timing_prog.sv
`timescale 1ns/1ps
module sim_xfer_timing_prog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] mode_code = 8'h00;
    logic       drive_sel = 1'b0;
    logic       fast_clk = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] port_data;
    logic       idx_wr, dat_wr, dat_rd, done, err, busy;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    xfer_timing_prog u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_code(mode_code),
        .drive_sel(drive_sel), .fast_clk(fast_clk), .rd_data(rd_data),
        .port_data(port_data), .idx_wr(idx_wr), .dat_wr(dat_wr),
        .dat_rd(dat_rd), .done(done), .err(err), .busy(busy)
    );

    // Register model behind the indexed port
    logic [7:0] regs [32];
    logic [7:0] cur_idx = 8'h00;
    logic [7:0] log_i [8];
    logic [7:0] log_v [8];
    int nlog = 0;
    int nrd = 0;
    int ndone = 0;
    int bad_seq = 0;
    logic wr_prev = 1'b0;
    logic idx_prev = 1'b0;
    logic [7:0] rd_idx = 8'h00;

    assign rd_data = regs[cur_idx[4:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        wr_prev <= dat_wr;
        idx_prev <= idx_wr;
        if (idx_wr) cur_idx <= port_data;
        if ((dat_wr || dat_rd) && !idx_prev) bad_seq <= bad_seq + 1;
        if (dat_wr) begin
            regs[cur_idx[4:0]] <= port_data;
            if (nlog < 8) begin
                log_i[nlog] <= cur_idx;
                log_v[nlog] <= port_data;
            end
            nlog <= nlog + 1;
        end
        if (dat_rd) begin
            nrd <= nrd + 1;
            rd_idx <= cur_idx;
        end
        if (done) ndone <= ndone + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent expectation from the requirement tables
    function automatic logic [23:0] exp_line(input logic [7:0] code);
        case (code)
            8'h40: return 24'h4A0FD5; 8'h41: return 24'h3A0AD0;
            8'h42: return 24'h2A07CD; 8'h43: return 24'h1A05CD;
            8'h44: return 24'h1A03CD; 8'h45: return 24'h1A02CB;
            8'h46: return 24'h1A01CB;
            8'h20: return 24'hDF5F00; 8'h21: return 24'h6B2700;
            8'h22: return 24'h692500;
            8'h08: return 24'hFB2BAC; 8'h09: return 24'h4629A4;
            8'h0A: return 24'h232664; 8'h0B: return 24'h270D35;
            8'h0C: return 24'h230925;
            default: return 24'h0;
        endcase
    endfunction

    function automatic logic [7:0] exp_idx(input logic [7:0] code, input int k);
        if (code[7:4] == 4'h4) return 8'h10 + 8'(k);
        if (code[7:4] == 4'h2) return 8'h0E + 8'(k);
        return (k == 2) ? 8'h13 : 8'h0C + 8'(k);
    endfunction

    // Run one request; returns err seen at done and whether a write preceded done
    task automatic run(input logic [7:0] code, input logic drv, input logic fst,
                       output logic err_seen, output logic wr_before);
        int t;
        @(negedge clk);
        nlog = 0; nrd = 0;
        mode_code = code; drive_sel = drv; fast_clk = fst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 40) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R10 done seen", done, 1);
        err_seen = err;
        wr_before = wr_prev;
        @(negedge clk);
        chk(!done, "R10 done one cycle", done, 0);
    endtask

    task automatic t_fast(input logic [7:0] code, input logic drv);
        logic e, w;
        int n;
        logic [23:0] ln;
        logic [7:0] ofs;
        run(code, drv, 1'b1, e, w);
        n = (code[7:4] == 4'h2) ? 2 : 3;
        ln = exp_line(code);
        ofs = drv ? 8'h08 : 8'h00;
        chk(nlog == n, "R3 R4 R5 write count", nlog, n);
        chk(!e, "R9 no err on valid", e, 0);
        chk(w, "R10 done after last write", w, 1);
        chk(nrd == 0, "R1 no reads in fast load", nrd, 0);
        for (int k = 0; k < n; k++) begin
            logic [7:0] ev;
            ev = ln[23 - 8*k -: 8];
            chk(log_i[k] == exp_idx(code, k) + ofs, "R2 index with offset",
                log_i[k], exp_idx(code, k) + ofs);
            chk(log_v[k] == ev, "R6 row byte", log_v[k], ev);
        end
    endtask

    task automatic t_fix(input logic drv, input logic [7:0] pre);
        logic e, w;
        logic [7:0] ix;
        ix = drv ? 8'h18 : 8'h10;
        regs[ix[4:0]] = pre;
        run(8'h42, drv, 1'b0, e, w);
        chk(nrd == 1, "R7 one read", nrd, 1);
        chk(rd_idx == ix, "R7 read index", rd_idx, ix);
        chk(nlog == 1, "R7 one write", nlog, 1);
        chk(log_i[0] == ix, "R7 write index", log_i[0], ix);
        chk(log_v[0] == (pre & 8'h7F), "R7 bit7 cleared", log_v[0], pre & 8'h7F);
        chk(!e, "R7 no err", e, 0);
    endtask

    task automatic t_slow_other(input logic [7:0] code);
        logic e, w;
        run(code, 1'b1, 1'b0, e, w);
        chk(nlog == 0 && nrd == 0, "R8 no access", nlog + nrd, 0);
        chk(!e, "R8 no err", e, 0);
    endtask

    task automatic t_bad(input logic [7:0] code, input logic fst);
        logic e, w;
        run(code, 1'b0, fst, e, w);
        chk(nlog == 0 && nrd == 0, "R9 no access on bad code", nlog + nrd, 0);
        chk(e, "R9 err with done", e, 1);
    endtask

    task automatic t_busy_ignore();
        int d0;
        int t;
        d0 = ndone;
        @(negedge clk);
        nlog = 0; nrd = 0;
        mode_code = 8'h0C; drive_sel = 1'b0; fast_clk = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R11 busy after start", busy, 1);
        @(negedge clk);
        mode_code = 8'h46; drive_sel = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (t < 30) begin
            @(negedge clk);
            t++;
        end
        chk(ndone - d0 == 1, "R11 single done", ndone - d0, 1);
        chk(nlog == 3, "R11 only first load", nlog, 3);
        chk(log_i[0] == 8'h0C && log_v[0] == 8'h23, "R11 first byte from PIO4",
            {log_i[0], log_v[0]}, 16'h0C23);
        chk(log_i[2] == 8'h13 && log_v[2] == 8'h25, "R11 last byte from PIO4",
            {log_i[2], log_v[2]}, 16'h1325);
        chk(!busy, "R11 idle after", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!idx_wr && !dat_wr && !dat_rd && !done && !err && !busy, "R12 reset state",
            {idx_wr, dat_wr, dat_rd, done, err, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R12 idle after reset", {busy, done}, 0);

        for (int m = 0; m <= 6; m++) t_fast(8'h40 + 8'(m), m[0]);   // R3
        for (int m = 0; m <= 2; m++) t_fast(8'h20 + 8'(m), !m[0]);  // R4
        for (int m = 0; m <= 4; m++) t_fast(8'h08 + 8'(m), m[0]);   // R5
        t_fix(1'b0, 8'hFF);                                          // R7
        t_fix(1'b1, 8'h2A);
        t_slow_other(8'h44);                                         // R8
        t_slow_other(8'h0A);
        t_bad(8'h47, 1'b1);                                          // R9
        t_bad(8'h0D, 1'b1);
        t_bad(8'h23, 1'b0);
        t_bad(8'hFF, 1'b1);
        t_busy_ignore();                                             // R11
        chk(bad_seq == 0, "R1 index before every data strobe", bad_seq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule